// File: doc/BRIEF.md
# STN Panel Scan Timing Generator

This block drives the row and column timing of a passive-matrix STN panel. It produces the column shift clock, the line latch pulse, the first-row marker, and the AC-drive polarity signal. In step with the column clock it produces the byte addresses from which a display memory feeds pixel data. A line is a programmable number of characters, one memory byte each. After them comes a horizontal sync interval whose length is also given in characters. A frame is twice the programmed half-line count.

The panel may be a single screen or two half-screens scanned in parallel. In the dual case each half has its own fetch address counter. That counter starts from its own start address and stays inside its own half of the memory. Start addresses are loaded a byte at a time. A new value takes effect only when its high byte is written, and the counters pick it up at the next frame boundary. A simple output gate blanks or inverts the pixel bus on its way to the panel.

Top module: `stn_scan_timing`

## Requirements
- R1: Each line consists of `chars_i` data slots followed by `lpw_i` sync slots. A slot lasts two clocks. In a data slot `cp_o` is high for the first clock and low for the second. `cp_o` stays low through every sync slot. Legal settings are `chars_i` 1 to 255 and `lpw_i` 3 to 255.
- R2: `lp_o` goes high at the start of the second sync slot and stays high for `lpw_i`−2 slots, that is 2·(`lpw_i`−2) clocks per line. `lp_o` is never high together with `cp_o`, and the last sync slot of a line has `lp_o` low.
- R3: A frame holds 2·`half_lines_i` lines (`half_lines_i` ≥ 1) in both single and dual mode.
- R4: `flm_o` is high for the whole sync portion of the first line of each frame and at no other time. That gives 2·`lpw_i` clocks per frame.
- R5: `m_o` resets to 0. With `m_period_i` = 0 it toggles once per frame, at the frame end. Otherwise it toggles at the end of every `m_period_i`-th line. It changes only on a line boundary.
- R6: Each fetch address advances by one at the end of every data slot and keeps counting across lines. At each frame end it is reloaded from its start address. After reset the upper address is 0000h and the lower address is 2580h.
- R7: In single mode (`dual_i`=0) both counters step through the full memory, 0000h to 4AFFh. From 4AFFh they wrap to 0000h.
- R8: In dual mode the upper counter stays in 0000h–257Fh and wraps to 0000h. The lower counter stays in 2580h–4AFFh and wraps to 2580h.
- R9: A start address is written through `sa_sel_i`: 0 writes the upper low byte, 1 the upper high byte, 2 the lower low byte and 3 the lower high byte. A low-byte write is only staged and leaves the address in use unchanged. A high-byte write commits {high byte, staged low byte} with bit 0 forced to 0. The committed value is used from the next frame reload.
- R10: `vd_o` equals `pix_i` when `disp_on_i`=1 and `reverse_i`=0. It equals ~`pix_i` when `disp_on_i`=1 and `reverse_i`=1. It is 00h when `disp_on_i`=0 and `reverse_i`=0, and FFh when `disp_on_i`=0 and `reverse_i`=1.
- R11: While `rst_ni` is low, `lp_o`, `flm_o` and `m_o` are 0 and the fetch addresses hold their R6 reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chars_i | input | 8 | Data characters (bytes) per line |
| lpw_i | input | 8 | Sync interval length in characters |
| half_lines_i | input | 8 | Half the number of lines per frame |
| m_period_i | input | 8 | AC-drive toggle period in lines, 0 = per frame |
| dual_i | input | 1 | 1 = two half-screens scanned in parallel |
| disp_on_i | input | 1 | Display enable for the data bus |
| reverse_i | input | 1 | Invert the data bus |
| pix_i | input | 8 | Pixel data from the memory path |
| sa_wr_i | input | 1 | Start-address byte write strobe |
| sa_sel_i | input | 2 | Start-address byte select (see R9) |
| sa_wdata_i | input | 8 | Start-address byte value |
| cp_o | output | 1 | Column shift clock |
| lp_o | output | 1 | Line latch pulse |
| flm_o | output | 1 | First-row marker |
| m_o | output | 1 | AC-drive polarity |
| fetch_addr1_o | output | 15 | Upper (or only) screen fetch address |
| fetch_addr2_o | output | 15 | Lower screen fetch address |
| vd_o | output | 8 | Panel data bus after blanking/inversion |

## Verification
The hardest cases to reach are the address wraps. The counters run upward from a start address for a whole frame, so they come near the 4AFFh or 257Fh boundaries only after a long run. The stimulus programs start addresses a few bytes below each boundary, using the staged byte writes. It then waits for the reload at the frame boundary and reads the address on the last clock of the next frame. By then the counter has crossed the wrap point. The same sequence confirms that a low-byte write alone leaves the reloaded address unchanged.

// File: rtl/stn_scan_pkg.sv
package stn_scan_pkg;

  // start-address byte select codes
  typedef enum logic [1:0] {
    SA_UP_LO = 2'd0,
    SA_UP_HI = 2'd1,
    SA_DN_LO = 2'd2,
    SA_DN_HI = 2'd3
  } sa_sel_e;

  localparam int unsigned NUM_SCREENS = 2;

endpackage

// File: rtl/scan_hcount.sv
module scan_hcount #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cr_i,
  input  logic [CW-1:0] lpw_i,
  output logic          in_sync_o,
  output logic          half_o,
  output logic [CW-1:0] hcnt_o,
  output logic          data_step_o,
  output logic          line_end_o
);

  logic          in_sync_q, half_q;
  logic [CW-1:0] hcnt_q;

  always_comb begin
    data_step_o = !in_sync_q && half_q;
    line_end_o  = in_sync_q && half_q && (hcnt_q == lpw_i - CW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_sync_q <= 1'b0;
      half_q    <= 1'b0;
      hcnt_q    <= '0;
    end else begin
      half_q <= !half_q;
      if (half_q) begin
        if (!in_sync_q) begin
          if (hcnt_q == cr_i - CW'(1)) begin
            in_sync_q <= 1'b1;
            hcnt_q    <= '0;
          end else begin
            hcnt_q <= hcnt_q + CW'(1);
          end
        end else if (line_end_o) begin
          in_sync_q <= 1'b0;
          hcnt_q    <= '0;
        end else begin
          hcnt_q <= hcnt_q + CW'(1);
        end
      end
    end
  end

  assign in_sync_o = in_sync_q;
  assign half_o    = half_q;
  assign hcnt_o    = hcnt_q;

endmodule

// File: rtl/scan_vcount.sv
module scan_vcount #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] slt_i,
  input  logic [CW-1:0] mt_i,
  input  logic          line_end_i,
  output logic          first_line_o,
  output logic          frame_end_o,
  output logic          m_o
);

  localparam int LW = CW + 1;

  logic [LW-1:0] line_q;
  logic [CW-1:0] mcnt_q;
  logic          m_q;

  always_comb begin
    frame_end_o  = line_end_i && (line_q == {slt_i, 1'b0} - LW'(1));
    first_line_o = (line_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      mcnt_q <= '0;
      m_q    <= 1'b0;
    end else if (line_end_i) begin
      line_q <= frame_end_o ? '0 : line_q + LW'(1);
      if (mt_i == '0) begin
        mcnt_q <= '0;
        if (frame_end_o) m_q <= !m_q;
      end else if (mcnt_q == mt_i - CW'(1)) begin
        mcnt_q <= '0;
        m_q    <= !m_q;
      end else begin
        mcnt_q <= mcnt_q + CW'(1);
      end
    end
  end

  assign m_o = m_q;

endmodule

// File: rtl/scan_start_regs.sv
module scan_start_regs
  import stn_scan_pkg::*;
#(
  parameter int MEM_BYTES = 19200,
  parameter int AW        = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    sel_i,
  input  logic [7:0]    wdata_i,
  output logic [AW-1:0] start1_o,
  output logic [AW-1:0] start2_o
);

  localparam logic [AW-1:0] HALF = AW'(MEM_BYTES / 2);

  logic [AW-1:0] start_q [NUM_SCREENS];

  for (genvar s = 0; s < NUM_SCREENS; s++) begin : g_scr
    localparam logic [AW-1:0] RST_VAL = (s == 0) ? '0 : HALF;
    localparam sa_sel_e       LO_CODE = (s == 0) ? SA_UP_LO : SA_DN_LO;
    localparam sa_sel_e       HI_CODE = (s == 0) ? SA_UP_HI : SA_DN_HI;

    logic [7:0] stage_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q    <= RST_VAL[7:0];
        start_q[s] <= RST_VAL;
      end else if (wr_i) begin
        if (sel_i == LO_CODE) stage_q <= {wdata_i[7:1], 1'b0};
        if (sel_i == HI_CODE) start_q[s] <= AW'({wdata_i, stage_q});
      end
    end
  end

  assign start1_o = start_q[0];
  assign start2_o = start_q[1];

endmodule

// File: rtl/scan_fetch.sv
module scan_fetch
  import stn_scan_pkg::*;
#(
  parameter int MEM_BYTES = 19200,
  parameter int AW        = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dual_i,
  input  logic          step_i,
  input  logic          reload_i,
  input  logic [AW-1:0] start1_i,
  input  logic [AW-1:0] start2_i,
  output logic [AW-1:0] addr1_o,
  output logic [AW-1:0] addr2_o
);

  localparam logic [AW-1:0] LAST = AW'(MEM_BYTES - 1);
  localparam logic [AW-1:0] HALF = AW'(MEM_BYTES / 2);

  logic [AW-1:0] start_w [NUM_SCREENS];
  logic [AW-1:0] addr_q  [NUM_SCREENS];

  assign start_w[0] = start1_i;
  assign start_w[1] = start2_i;

  for (genvar s = 0; s < NUM_SCREENS; s++) begin : g_scr
    localparam logic [AW-1:0] BASE = (s == 0) ? '0 : HALF;
    localparam logic [AW-1:0] TOP  = (s == 0) ? HALF - AW'(1) : LAST;

    logic [AW-1:0] lo, hi, nxt;

    always_comb begin
      lo  = dual_i ? BASE : '0;
      hi  = dual_i ? TOP  : LAST;
      nxt = (addr_q[s] == hi) ? lo : addr_q[s] + AW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       addr_q[s] <= BASE;
      else if (reload_i) addr_q[s] <= start_w[s];
      else if (step_i)   addr_q[s] <= nxt;
    end
  end

  assign addr1_o = addr_q[0];
  assign addr2_o = addr_q[1];

endmodule

// File: rtl/stn_scan_timing.sv
module stn_scan_timing #(
  parameter int  MEM_BYTES = 19200,
  localparam int AW        = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    chars_i,
  input  logic [7:0]    lpw_i,
  input  logic [7:0]    half_lines_i,
  input  logic [7:0]    m_period_i,
  input  logic          dual_i,
  input  logic          disp_on_i,
  input  logic          reverse_i,
  input  logic [7:0]    pix_i,
  input  logic          sa_wr_i,
  input  logic [1:0]    sa_sel_i,
  input  logic [7:0]    sa_wdata_i,
  output logic          cp_o,
  output logic          lp_o,
  output logic          flm_o,
  output logic          m_o,
  output logic [AW-1:0] fetch_addr1_o,
  output logic [AW-1:0] fetch_addr2_o,
  output logic [7:0]    vd_o
);

  localparam int CW = 8;

  logic          in_sync, half, data_step, line_end;
  logic [CW-1:0] hcnt;
  logic          first_line, frame_end;
  logic [AW-1:0] start1, start2;

  scan_hcount #(.CW(CW)) u_h (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cr_i        (chars_i),
    .lpw_i       (lpw_i),
    .in_sync_o   (in_sync),
    .half_o      (half),
    .hcnt_o      (hcnt),
    .data_step_o (data_step),
    .line_end_o  (line_end)
  );

  scan_vcount #(.CW(CW)) u_v (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slt_i        (half_lines_i),
    .mt_i         (m_period_i),
    .line_end_i   (line_end),
    .first_line_o (first_line),
    .frame_end_o  (frame_end),
    .m_o          (m_o)
  );

  scan_start_regs #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_sa (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (sa_wr_i),
    .sel_i    (sa_sel_i),
    .wdata_i  (sa_wdata_i),
    .start1_o (start1),
    .start2_o (start2)
  );

  scan_fetch #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_f (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dual_i   (dual_i),
    .step_i   (data_step),
    .reload_i (frame_end),
    .start1_i (start1),
    .start2_i (start2),
    .addr1_o  (fetch_addr1_o),
    .addr2_o  (fetch_addr2_o)
  );

  // LP skips the first sync slot and the last one (width LPW-2)
  always_comb begin
    cp_o  = !in_sync && !half;
    lp_o  = in_sync && (hcnt != '0) &&
            (({1'b0, hcnt} + 9'd2) <= {1'b0, lpw_i});
    flm_o = in_sync && first_line;
    vd_o  = disp_on_i ? (pix_i ^ {8{reverse_i}}) : {8{reverse_i}};
  end

endmodule

// File: rtl/stn_scan_timing_chk.sv
module stn_scan_timing_chk #(
  parameter int MEM_BYTES = 19200,
  parameter int AW        = $clog2(MEM_BYTES)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dual_i,
  input logic          cp_o,
  input logic          lp_o,
  input logic          flm_o,
  input logic          m_o,
  input logic [AW-1:0] fetch_addr1_o,
  input logic [AW-1:0] fetch_addr2_o
);

  localparam logic [AW-1:0] HALF = AW'(MEM_BYTES / 2);
  localparam logic [AW-1:0] LAST = AW'(MEM_BYTES - 1);

  // R1
  cp_one_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cp_o) |=> !cp_o);

  // R2
  cp_lp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cp_o && lp_o));

  // R2
  lp_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lp_o) |-> !cp_o);

  // R4
  flm_in_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flm_o |-> !cp_o);

  // R5
  m_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(m_o) |-> $past(!cp_o && !lp_o));

  // R7
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_addr1_o <= LAST) && (fetch_addr2_o <= LAST));

  // R8
  dual_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_i |-> (fetch_addr1_o < HALF) && (fetch_addr2_o >= HALF));

endmodule

bind stn_scan_timing stn_scan_timing_chk #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dual_i        (dual_i),
  .cp_o          (cp_o),
  .lp_o          (lp_o),
  .flm_o         (flm_o),
  .m_o           (m_o),
  .fetch_addr1_o (fetch_addr1_o),
  .fetch_addr2_o (fetch_addr2_o)
);

// File: tb/stn_scan_timing_test.sv
`timescale 1ns/1ps
module stn_scan_timing_test;

  typedef struct packed {
    int cr; int lpw; int slt; int mt; int dual;
    int len; int cps; int lps; int flms; int mtog; int end1; int end2;
  } vec_t;

  // len = 2*(cr+lpw)*2*slt ; cps = cr*2*slt ; lps = 2*(lpw-2)*2*slt ; flms = 2*lpw
  localparam vec_t VECS [4] = '{
    '{3, 4, 2, 0, 0, 56, 12, 16,  8, 1, 12, 32'h258C},
    '{5, 3, 1, 1, 0, 32, 10,  4,  6, 2, 10, 32'h258A},
    '{2, 6, 3, 2, 1, 96, 12, 48, 12, 3, 12, 32'h258C},
    '{4, 5, 2, 3, 0, 72, 16, 24, 10, 1, 16, 32'h2590}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  chars_i = 8'd3, lpw_i = 8'd4, half_lines_i = 8'd2, m_period_i = 8'd0;
  logic        dual_i = 1'b0, disp_on_i = 1'b1, reverse_i = 1'b0;
  logic [7:0]  pix_i = 8'h00;
  logic        sa_wr_i = 1'b0;
  logic [1:0]  sa_sel_i = 2'd0;
  logic [7:0]  sa_wdata_i = 8'h00;
  logic        cp_o, lp_o, flm_o, m_o;
  logic [14:0] fetch_addr1_o, fetch_addr2_o;
  logic [7:0]  vd_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  stn_scan_timing uut (
    .clk_i, .rst_ni, .chars_i, .lpw_i, .half_lines_i, .m_period_i, .dual_i,
    .disp_on_i, .reverse_i, .pix_i, .sa_wr_i, .sa_sel_i, .sa_wdata_i,
    .cp_o, .lp_o, .flm_o, .m_o, .fetch_addr1_o, .fetch_addr2_o, .vd_o
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic start_reset(input vec_t v);
    rst_ni = 1'b0;
    #1;
    chars_i = 8'(v.cr); lpw_i = 8'(v.lpw); half_lines_i = 8'(v.slt);
    m_period_i = 8'(v.mt); dual_i = v.dual[0];
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic sa_write(input logic [1:0] sel, input logic [7:0] d);
    sa_wr_i = 1'b1; sa_sel_i = sel; sa_wdata_i = d;
    step(1);
    sa_wr_i = 1'b0;
  endtask

  task automatic measure(input int len, output int cps, output int lps,
                         output int flms, output int mtog,
                         output int e1, output int e2, output int r1, output int r2);
    logic pm;
    cps = 0; lps = 0; flms = 0; mtog = 0; e1 = 0; e2 = 0;
    pm = m_o;
    for (int i = 0; i < len; i++) begin
      cps += int'(cp_o); lps += int'(lp_o); flms += int'(flm_o);
      if (m_o != pm) mtog++;
      pm = m_o;
      if (i == len - 1) begin e1 = int'(fetch_addr1_o); e2 = int'(fetch_addr2_o); end
      step(1);
    end
    if (m_o != pm) mtog++;
    r1 = int'(fetch_addr1_o); r2 = int'(fetch_addr2_o);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cps, lps, flms, mtog, e1, e2, r1, r2;

    // R11: reset state
    start_reset(VECS[0]);
    check("R11 lp", int'(lp_o), 0);
    check("R11 flm", int'(flm_o), 0);
    check("R11 m", int'(m_o), 0);
    check("R11 addr1", int'(fetch_addr1_o), 0);
    check("R11 addr2", int'(fetch_addr2_o), 32'h2580);

    // main vector table
    foreach (VECS[k]) begin
      start_reset(VECS[k]);
      rst_ni = 1'b1;
      measure(VECS[k].len, cps, lps, flms, mtog, e1, e2, r1, r2);
      check("R1 cp high clocks", cps, VECS[k].cps);
      check("R2 lp high clocks", lps, VECS[k].lps);
      check("R4 flm high clocks", flms, VECS[k].flms);
      check("R5 m toggles", mtog, VECS[k].mtog);
      check("R6 addr1 at frame end", e1, VECS[k].end1);
      check("R6 addr2 at frame end", e2, VECS[k].end2);
      check("R3 addr1 reload after frame", r1, 0);
      check("R3 addr2 reload after frame", r2, 32'h2580);
    end

    // R9 and R7: staged low byte, commit on high byte, single-mode wrap
    start_reset(VECS[0]);
    rst_ni = 1'b1;
    sa_write(2'd0, 8'hFF);
    step(55);
    check("R9 low byte alone not committed", int'(fetch_addr1_o), 0);
    sa_write(2'd1, 8'h4A);
    step(55);
    check("R9 commit with even address", int'(fetch_addr1_o), 32'h4AFE);
    step(55);
    check("R7 single wrap 4AFF->0", int'(fetch_addr1_o), 32'h000A);

    // R8: dual-mode wraps inside each half
    start_reset('{3, 4, 2, 0, 1, 56, 0, 0, 0, 0, 0, 0});
    rst_ni = 1'b1;
    sa_write(2'd0, 8'h7C);
    sa_write(2'd1, 8'h25);
    sa_write(2'd2, 8'hFC);
    sa_write(2'd3, 8'h4A);
    step(52);
    check("R8 upper start", int'(fetch_addr1_o), 32'h257C);
    check("R8 lower start", int'(fetch_addr2_o), 32'h4AFC);
    step(55);
    check("R8 upper wrap to 0000", int'(fetch_addr1_o), 32'h0008);
    check("R8 lower wrap to 2580", int'(fetch_addr2_o), 32'h2588);

    // R10: data gating
    pix_i = 8'h5A;
    disp_on_i = 1'b1; reverse_i = 1'b0; #1;
    check("R10 normal", int'(vd_o), 32'h5A);
    reverse_i = 1'b1; #1;
    check("R10 reverse", int'(vd_o), 32'hA5);
    disp_on_i = 1'b0; reverse_i = 1'b0; #1;
    check("R10 blank", int'(vd_o), 32'h00);
    reverse_i = 1'b1; #1;
    check("R10 blank reversed", int'(vd_o), 32'hFF);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule